// File: doc/BRIEF.md
# Programmable Timer Channel Array

This block holds a 16-bit up-counter with a power-of-two prescaler in front of it. The counter drives four channels. Each channel can be set up for input capture or for output compare. On capture, the channel stores the counter value when a chosen edge arrives on its input pin. On compare, the channel acts on its output pin when the counter reaches the stored value. A compare channel can also run as a simple PWM generator: its pin rises when the counter returns to zero and falls at the compare match.

The counter either wraps at full scale or returns to zero after reaching a programmed modulo value. A separate 16-bit accumulator counts edges on its own input pin, or counts prescaled clock ticks while that pin is held at its active level. Software reaches all state through a single-cycle synchronous register port. Reads are combinational from the address. Events appear as sticky per-channel flags and an overflow flag, and each flag is cleared by writing a one to its bit.

Register map (word addresses):
- 0: control. Bit 0 runs the counter. Bits 3:1 hold the prescaler select s. Bit 4 enables the modulo reset. Bit 5 enables the accumulator. Bit 6 selects gated mode (0 selects edge counting). Bit 7 sets the accumulator polarity (1 = rising edge or high level).
- 1: channel modes. Channel i owns bits 4i+3:4i. Within that nibble, bit 0 selects compare (0 selects capture), bits 2:1 select the edge or action, and bit 3 selects PWM.
- 2: flags, write one to clear. Bits 3:0 are the channel flags and bit 4 is the overflow flag.
- 3: modulo value.
- 4 to 7: channel 0 to 3 value (compare value or captured value).
- 8: accumulator.
- 9: counter.

Top module: `tmr_array`

## Requirements
- R1: While bit 0 of control is set, the counter advances by one on every 2^s-th clock, where s is control bits 3:1 (range 0..7). The first advance comes 2^s clocks after the counter is started or written. While bit 0 is clear, the counter holds. A write to address 9 loads the counter and restarts the prescaler.
- R2: With the modulo reset off, an advance from 0xFFFF gives 0x0000 and sets the overflow flag (flags bit 4).
- R3: With control bit 4 set, an advance while the counter equals the modulo value gives 0 and sets the overflow flag.
- R4: A capture channel copies the counter into its value register and sets its flag on the selected input edge. The edge code in mode bits 2:1 is 01 for rising, 10 for falling and 11 for both. The copy and the flag are visible the clock after the edge is sampled.
- R5: A capture channel ignores an input edge of the unselected direction: its value register and its flag stay unchanged.
- R6: On a compare channel (mode bit 0 = 1, bit 3 = 0), an advance while the counter equals the channel value sets the flag. The pin action is given by bits 2:1: 01 clears the pin, 10 sets it, 11 toggles it, 00 leaves it alone.
- R7: In PWM mode (mode bits 3 and 0 set), the pin goes to 1 on an advance that returns the counter to zero. It goes to 0 on a compare match, and the match wins if both happen together.
- R8: Writing 1 to a flag bit clears that flag. If a new event for the same flag arrives in the same cycle, the flag stays set. Flags never clear on their own.
- R9: In edge-counting mode (control bits 5 = 1, 6 = 0), the accumulator increments once per active edge of the accumulator input. The active edge is rising when bit 7 = 1 and falling when bit 7 = 0.
- R10: In gated mode (control bits 5 and 6 set), the accumulator increments on each counter advance during which the accumulator input is at the level given by bit 7.
- R11: After reset, every register reads zero and every pin and flag output is low. Values written to the modulo, channel and accumulator addresses read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 4 | Register word address |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data for `addr`, combinational |
| chIn | input | 4 | Capture inputs, one per channel |
| accIn | input | 1 | Accumulator event or gate input |
| chPin | output | 4 | Compare and PWM outputs |
| chFlag | output | 4 | Sticky channel event flags |
| ovfFlag | output | 1 | Sticky counter overflow flag |

## Verification
A register write and a capture edge each take effect at the first rising clock edge after they are driven. Their results are readable half a cycle later. A counter started or loaded at edge 0 shows floor(n/2^s) advances after n further edges, and a compare match at value C changes the pin and flag after edge C+1. The bench drives inputs on falling edges, counts rising edges explicitly between stimulus and sampling, and reads results shortly after the falling edge. Every expected value therefore comes from these edge counts through small bench functions.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CNT_W  = 16;
  localparam int NUM_CH = 4;
  localparam int SEL_W  = 3;
  localparam int PRE_W  = (1 << SEL_W) - 1;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_CTRL = 4'd0;
  localparam logic [ADDR_W-1:0] A_MODE = 4'd1;
  localparam logic [ADDR_W-1:0] A_FLAG = 4'd2;
  localparam logic [ADDR_W-1:0] A_MOD  = 4'd3;
  localparam logic [ADDR_W-1:0] A_CH0  = 4'd4;
  localparam logic [ADDR_W-1:0] A_ACC  = 4'd8;
  localparam logic [ADDR_W-1:0] A_CNT  = 4'd9;

  typedef struct packed {
    logic             accPol;
    logic             accGated;
    logic             accEn;
    logic             modEn;
    logic [SEL_W-1:0] psel;
    logic             run;
  } ctrl_t;

  typedef struct packed {
    logic       pwm;
    logic [1:0] sel;
    logic       isCmp;
  } chcfg_t;

  typedef struct packed {
    logic              tick;
    logic              wrCnt;
    logic              wrMod;
    logic              wrAcc;
    logic [NUM_CH-1:0] wrCh;
    logic [NUM_CH:0]   clrFlag;
    logic [NUM_CH-1:0] capHit;
    logic              accInc;
    logic [CNT_W-1:0]  data;
  } strobe_t;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     wrEn,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [CNT_W-1:0]         wrData,
  input  logic [NUM_CH-1:0]        chIn,
  input  logic                     accIn,
  output ctrl_t                    ctrlReg,
  output chcfg_t [NUM_CH-1:0]      modeReg,
  output strobe_t                  stb
);
  logic [PRE_W-1:0]  preCnt;
  logic [PRE_W-1:0]  preMask;
  logic [NUM_CH-1:0] chInPrev;
  logic              accPrev;
  logic              wrCntHit;
  logic              accEdge;

  assign wrCntHit = wrEn && (addr == A_CNT);
  assign preMask  = ~({PRE_W{1'b1}} << ctrlReg.psel);
  assign accEdge  = ctrlReg.accPol ? (accIn & ~accPrev) : (~accIn & accPrev);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg  <= '0;
      modeReg  <= '0;
      preCnt   <= '0;
      chInPrev <= '0;
      accPrev  <= 1'b0;
    end else begin
      if (wrEn && addr == A_CTRL) ctrlReg <= ctrl_t'(wrData[$bits(ctrl_t)-1:0]);
      if (wrEn && addr == A_MODE) modeReg <= wrData[NUM_CH*4-1:0];
      if (!ctrlReg.run || wrCntHit) preCnt <= '0;
      else                          preCnt <= preCnt + 1'b1;
      chInPrev <= chIn;
      accPrev  <= accIn;
    end
  end

  always_comb begin
    stb         = '0;
    stb.data    = wrData;
    stb.wrCnt   = wrCntHit;
    stb.wrMod   = wrEn && (addr == A_MOD);
    stb.wrAcc   = wrEn && (addr == A_ACC);
    stb.clrFlag = (wrEn && addr == A_FLAG) ? wrData[NUM_CH:0] : '0;
    stb.tick    = ctrlReg.run && !wrCntHit && ((preCnt & preMask) == preMask);
    stb.accInc  = ctrlReg.accEn &&
                  (ctrlReg.accGated ? (stb.tick && (accIn == ctrlReg.accPol)) : accEdge);
    for (int i = 0; i < NUM_CH; i++) begin
      stb.wrCh[i]   = wrEn && (addr == ADDR_W'(int'(A_CH0) + i));
      stb.capHit[i] = !modeReg[i].isCmp &&
                      ((modeReg[i].sel[0] && chIn[i] && !chInPrev[i]) ||
                       (modeReg[i].sel[1] && !chIn[i] && chInPrev[i]));
    end
  end
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  strobe_t                       stb,
  input  logic                          modEn,
  input  chcfg_t [NUM_CH-1:0]           modeReg,
  output logic [CNT_W-1:0]              cnt,
  output logic [CNT_W-1:0]              modulo,
  output logic [CNT_W-1:0]              acc,
  output logic [NUM_CH-1:0][CNT_W-1:0]  chReg,
  output logic [NUM_CH-1:0]             chPin,
  output logic [NUM_CH-1:0]             chFlag,
  output logic                          ovfFlag
);
  logic wrapHit;
  logic wrapEv;

  assign wrapHit = modEn ? (cnt == modulo) : (cnt == {CNT_W{1'b1}});
  assign wrapEv  = stb.tick && wrapHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      modulo  <= '0;
      acc     <= '0;
      ovfFlag <= 1'b0;
    end else begin
      if (stb.wrCnt)     cnt <= stb.data;
      else if (stb.tick) cnt <= wrapHit ? '0 : cnt + 1'b1;
      if (stb.wrMod)       modulo <= stb.data;
      if (stb.wrAcc)       acc <= stb.data;
      else if (stb.accInc) acc <= acc + 1'b1;
      ovfFlag <= (ovfFlag && !stb.clrFlag[NUM_CH]) || wrapEv;
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic             pinQ;
    logic             flagQ;
    logic [CNT_W-1:0] regQ;
    logic             match;

    assign match    = stb.tick && modeReg[i].isCmp && (cnt == regQ);
    assign chPin[i] = pinQ;
    assign chFlag[i] = flagQ;
    assign chReg[i] = regQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pinQ  <= 1'b0;
        flagQ <= 1'b0;
        regQ  <= '0;
      end else begin
        if (stb.capHit[i])    regQ <= cnt;
        else if (stb.wrCh[i]) regQ <= stb.data;
        flagQ <= (flagQ && !stb.clrFlag[i]) || stb.capHit[i] || match;
        if (modeReg[i].isCmp) begin
          if (modeReg[i].pwm) begin
            if (match)       pinQ <= 1'b0;
            else if (wrapEv) pinQ <= 1'b1;
          end else if (match) begin
            case (modeReg[i].sel)
              2'b01:   pinQ <= 1'b0;
              2'b10:   pinQ <= 1'b1;
              2'b11:   pinQ <= ~pinQ;
              default: pinQ <= pinQ;
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/tmr_array.sv
module tmr_array
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [3:0]        addr,
  input  logic [15:0]       wrData,
  output logic [15:0]       rdData,
  input  logic [3:0]        chIn,
  input  logic              accIn,
  output logic [3:0]        chPin,
  output logic [3:0]        chFlag,
  output logic              ovfFlag
);
  ctrl_t                         ctrlReg;
  chcfg_t [NUM_CH-1:0]           modeReg;
  strobe_t                       stb;
  logic [CNT_W-1:0]              cnt;
  logic [CNT_W-1:0]              modulo;
  logic [CNT_W-1:0]              acc;
  logic [NUM_CH-1:0][CNT_W-1:0]  chReg;

  tmr_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .chIn(chIn), .accIn(accIn), .ctrlReg(ctrlReg), .modeReg(modeReg), .stb(stb)
  );

  tmr_datapath i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .modEn(ctrlReg.modEn), .modeReg(modeReg),
    .cnt(cnt), .modulo(modulo), .acc(acc), .chReg(chReg),
    .chPin(chPin), .chFlag(chFlag), .ovfFlag(ovfFlag)
  );

  always_comb begin
    rdData = '0;
    case (addr)
      A_CTRL:  rdData = CNT_W'(ctrlReg);
      A_MODE:  rdData = CNT_W'(modeReg);
      A_FLAG:  rdData = CNT_W'({ovfFlag, chFlag});
      A_MOD:   rdData = modulo;
      A_ACC:   rdData = acc;
      A_CNT:   rdData = cnt;
      default: rdData = '0;
    endcase
    for (int i = 0; i < NUM_CH; i++)
      if (addr == ADDR_W'(int'(A_CH0) + i)) rdData = chReg[i];
  end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
  import tmr_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              run,
  input logic              modEn,
  input logic              tick,
  input logic              wrCnt,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  modulo,
  input logic [NUM_CH-1:0] capHit,
  input logic [NUM_CH-1:0] chFlag,
  input logic              ovfFlag,
  input logic              clrOvf
);
  assert_cnt_step_R1: assert property (@(posedge clk) disable iff (!rstN)
    tick && !modEn && cnt != {CNT_W{1'b1}} |=> cnt == CNT_W'($past(cnt) + 1'b1));

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    !run && !wrCnt |=> $stable(cnt));

  assert_full_wrap_R2: assert property (@(posedge clk) disable iff (!rstN)
    tick && !modEn && cnt == {CNT_W{1'b1}} |=> cnt == '0 && ovfFlag);

  assert_mod_wrap_R3: assert property (@(posedge clk) disable iff (!rstN)
    tick && modEn && cnt == modulo |=> cnt == '0 && ovfFlag);

  assert_cap_flag_R4: assert property (@(posedge clk) disable iff (!rstN)
    capHit != '0 |=> (chFlag & $past(capHit)) == $past(capHit));

  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    ovfFlag && !clrOvf |=> ovfFlag);
endmodule

bind tmr_array tmr_checker i_chk (
  .clk(clk), .rstN(rstN), .run(ctrlReg.run), .modEn(ctrlReg.modEn),
  .tick(stb.tick), .wrCnt(stb.wrCnt), .cnt(cnt), .modulo(modulo),
  .capHit(stb.capHit), .chFlag(chFlag), .ovfFlag(ovfFlag),
  .clrOvf(stb.clrFlag[4])
);

// File: tb/test_tmr_array.sv
module test_tmr_array;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic [3:0]  chIn = '0;
  logic        accIn = 1'b0;
  logic [3:0]  chPin;
  logic [3:0]  chFlag;
  logic        ovfFlag;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  tmr_array i_tmr_array (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .chIn(chIn), .accIn(accIn), .chPin(chPin),
    .chFlag(chFlag), .ovfFlag(ovfFlag)
  );

  always #2 clk = ~clk;

  function automatic int expCount(int n, int s, bit modOn, int m);
    int t = n >> s;
    return modOn ? (t % (m + 1)) : (t & 16'hFFFF);
  endfunction

  function automatic bit expOvf(int n, int s, bit modOn, int m);
    return modOn ? ((n >> s) >= m + 1) : ((n >> s) >= 65536);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic writeReg(logic [3:0] a, logic [15:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(posedge clk); @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readReg(logic [3:0] a, output logic [15:0] v);
    addr = a; #1; v = rdData;
  endtask

  task automatic waitEdges(int n);
    repeat (n) begin @(posedge clk); end
    @(negedge clk);
  endtask

  task automatic finishUp();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    finishUp();
  end

  initial begin
    logic [15:0] v;
    process::self().srandom(32'd1234);
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R11 reset state
    for (int a = 0; a < 10; a++) begin
      readReg(4'(a), v); check("R11 reset read", v, 0);
    end
    check("R11 reset outputs", {chPin, chFlag, ovfFlag}, 0);
    writeReg(4'd3, 16'hBEEF); readReg(4'd3, v); check("R11 modulo readback", v, 16'hBEEF);
    writeReg(4'd6, 16'h1357); readReg(4'd6, v); check("R11 channel readback", v, 16'h1357);
    writeReg(4'd8, 16'h2468); readReg(4'd8, v); check("R11 acc readback", v, 16'h2468);

    // R1 / R3 random counter runs
    for (int it = 0; it < 12; it++) begin
      int s = $urandom % 4;
      int n = $urandom % 300;
      bit modOn = $urandom % 2;
      int m = 5 + $urandom % 50;
      writeReg(4'd0, 16'h0000);
      writeReg(4'd9, 16'h0000);
      writeReg(4'd3, 16'(m));
      writeReg(4'd2, 16'h001F);
      writeReg(4'd0, 16'(1 | (s << 1) | (modOn << 4)));
      waitEdges(n);
      readReg(4'd9, v);
      check(modOn ? "R3 modulo count" : "R1 prescaled count", v, expCount(n, s, modOn, m));
      check("R3 overflow flag", ovfFlag, expOvf(n, s, modOn, m));
    end

    // R1 hold while stopped, and counter load
    writeReg(4'd0, 16'h0000);
    writeReg(4'd9, 16'h0ABC);
    waitEdges(5);
    readReg(4'd9, v); check("R1 hold when stopped", v, 16'h0ABC);

    // R2 full-scale wrap
    writeReg(4'd2, 16'h001F);
    writeReg(4'd9, 16'hFFFE);
    writeReg(4'd0, 16'h0001);
    waitEdges(1);
    readReg(4'd9, v); check("R2 before wrap", v, 16'hFFFF);
    check("R2 no overflow yet", ovfFlag, 0);
    waitEdges(1);
    readReg(4'd9, v); check("R2 wrapped", v, 0);
    check("R2 overflow set", ovfFlag, 1);

    // R6 compare actions on channel 3
    begin
      int c = 3 + $urandom % 40;
      logic p0;
      writeReg(4'd0, 16'h0000);
      writeReg(4'd9, 16'h0000);
      writeReg(4'd7, 16'(c));
      writeReg(4'd1, 16'h7000);
      writeReg(4'd2, 16'h001F);
      p0 = chPin[3];
      writeReg(4'd0, 16'h0001);
      waitEdges(c);
      check("R6 toggle before match", chPin[3], p0);
      check("R6 flag before match", chFlag[3], 0);
      waitEdges(1);
      check("R6 toggle at match", chPin[3], !p0);
      check("R6 flag at match", chFlag[3], 1);
      writeReg(4'd0, 16'h0000); writeReg(4'd9, 16'h0000);
      writeReg(4'd1, 16'h5000); writeReg(4'd0, 16'h0001);
      waitEdges(c + 1);
      check("R6 set action", chPin[3], 1);
      writeReg(4'd0, 16'h0000); writeReg(4'd9, 16'h0000);
      writeReg(4'd1, 16'h3000); writeReg(4'd0, 16'h0001);
      waitEdges(c + 1);
      check("R6 clear action", chPin[3], 0);
    end

    // R7 PWM with modulo period
    writeReg(4'd0, 16'h0000);
    writeReg(4'd3, 16'd20);
    writeReg(4'd9, 16'h0000);
    writeReg(4'd7, 16'd7);
    writeReg(4'd1, 16'h9000);
    writeReg(4'd0, 16'h0011);
    waitEdges(8);
    check("R7 pwm low after match", chPin[3], 0);
    waitEdges(13);
    check("R7 pwm high after wrap", chPin[3], 1);
    waitEdges(8);
    check("R7 pwm low again", chPin[3], 0);
    writeReg(4'd0, 16'h0000);

    // R4 / R5 capture
    writeReg(4'd1, 16'h0642);
    writeReg(4'd5, 16'h1234);
    writeReg(4'd9, 16'h0321);
    writeReg(4'd2, 16'h001F);
    chIn[0] = 1'b1; waitEdges(1);
    readReg(4'd4, v); check("R4 rising capture", v, 16'h0321);
    check("R4 capture flag", chFlag[0], 1);
    chIn[1] = 1'b1; waitEdges(1);
    readReg(4'd5, v); check("R5 unselected edge value", v, 16'h1234);
    check("R5 unselected edge flag", chFlag[1], 0);
    writeReg(4'd9, 16'h0777);
    chIn[1] = 1'b0; waitEdges(1);
    readReg(4'd5, v); check("R4 falling capture", v, 16'h0777);
    check("R4 falling flag", chFlag[1], 1);
    for (int it = 0; it < 6; it++) begin
      logic [15:0] z = 16'($urandom);
      writeReg(4'd9, z);
      writeReg(4'd2, 16'h001F);
      chIn[2] = ~chIn[2]; waitEdges(1);
      readReg(4'd6, v); check("R4 both-edge capture", v, z);
      check("R4 both-edge flag", chFlag[2], 1);
    end

    // R8 clear and event priority
    chIn[0] = 1'b0; waitEdges(1);
    writeReg(4'd2, 16'h001F);
    check("R8 flag cleared", chFlag[0], 0);
    chIn[0] = 1'b1;
    writeReg(4'd2, 16'h0001);
    check("R8 event beats clear", chFlag[0], 1);
    writeReg(4'd2, 16'h0001);
    check("R8 clear without event", chFlag[0], 0);

    // R9 edge counting, both polarities
    writeReg(4'd0, 16'h00A0);
    writeReg(4'd8, 16'h0000);
    begin
      int n = 3 + $urandom % 8;
      for (int p = 0; p < n; p++) begin
        accIn = 1'b1; waitEdges(1); accIn = 1'b0; waitEdges(1);
      end
      readReg(4'd8, v); check("R9 rising edge count", v, n);
      writeReg(4'd0, 16'h0020);
      writeReg(4'd8, 16'h0000);
      n = 3 + $urandom % 8;
      for (int p = 0; p < n; p++) begin
        accIn = 1'b1; waitEdges(1); accIn = 1'b0; waitEdges(1);
      end
      readReg(4'd8, v); check("R9 falling edge count", v, n);
    end

    // R10 gated accumulation
    for (int it = 0; it < 4; it++) begin
      int s = $urandom % 4;
      int n = 10 + $urandom % 100;
      writeReg(4'd0, 16'h0000);
      writeReg(4'd8, 16'h0000);
      writeReg(4'd9, 16'h0000);
      writeReg(4'd0, 16'(16'h00E1 | (s << 1)));
      accIn = 1'b1; waitEdges(n); accIn = 1'b0;
      waitEdges(3);
      readReg(4'd8, v); check("R10 gated count", v, n >> s);
    end

    finishUp();
  end
endmodule